// File: doc/BRIEF.md
# Trigger pad cluster finder

This block receives one wide vector of trigger pad hit bits on every bunch-crossing clock. It reduces that vector to a short, fixed-size list of clusters. A cluster is a run of adjacent hit pads. It is described by the address of its lowest pad and by its length, stored as length minus one.

The pads are divided into equal partitions of consecutive addresses. A cluster never spans two partitions, and it never grows beyond a fixed maximum length. Longer runs are cut into several clusters.

The block reports at most a fixed number of clusters per crossing. The lowest addresses are reported first, and any further clusters are discarded. It accepts a new vector on every clock without stalling. Each result appears after a fixed latency of three register stages.

With default parameters the block covers 1536 pads. These come from 24 front-end chips of 64 pads each and are arranged as 8 partitions of 192 pads. The block reports up to 8 clusters of up to 8 pads each, with an 11-bit address and a 3-bit length field per slot.

Top module: `trig_cluster_finder`

## Requirements
- R1: While `rst_n` is low, and on the first output after its release, every bit of `clu_valid` is 0.
- R2: The vector on `pad_hits` sampled at rising edge n is reflected on the outputs right after rising edge n+2. A different vector may be applied at every edge, and each one is reported independently.
- R3: A cluster is a maximal run of hit pads. Its slot carries the address of the run's lowest pad and a length field equal to the number of pads minus one.
- R4: Pads p and p+1 belong to different partitions when (p+1) is a multiple of `PART_PADS`. A run crossing that point ends at p, and pad p+1 starts a new cluster.
- R5: In a run longer than `MAX_SIZE` pads, the first `MAX_SIZE` pads form one cluster. The remaining pads are split the same way, so each piece starts a new cluster.
- R6: Clusters fill slots in rising order of start address, with the lowest address in slot 0. The valid slots form a contiguous group starting at slot 0.
- R7: At most `MAX_CLUST` clusters are reported, and any clusters with higher start addresses are dropped. An unused slot has valid 0, address 0 and length field 0.
- R8: Slot k uses `clu_valid[k]`, `clu_addr[k*ADDR_W +: ADDR_W]` and `clu_size[k*SIZE_W +: SIZE_W]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_hits | input | N_PADS | Pad hit bits, bit p is pad address p |
| clu_valid | output | MAX_CLUST | Per-slot valid flag |
| clu_addr | output | MAX_CLUST*ADDR_W | Per-slot start pad address |
| clu_size | output | MAX_CLUST*SIZE_W | Per-slot cluster length minus one |

## Verification
The hardest situation to reach from the ports combines three conditions in one vector: a run that both exceeds the length cap and reaches a partition edge, more clusters than there are slots, and a different vector on the very next clock. The bench uses a small configuration of 48 pads in four 12-pad partitions, with 4 slots and a length cap of 4. It walks every 12-bit pattern, derives the contents of all four partitions from it, and changes the vector on every clock. In this way every combination of split point, partition edge and overflow passes through the pipeline back to back. Directed vectors then pin down the individual boundary cases with hand-computed slot values.

// File: rtl/cf_pkg.sv
package cf_pkg;
    localparam int CF_PADS  = 1536;
    localparam int CF_PART  = 192;
    localparam int CF_SLOTS = 8;
    localparam int CF_RUN   = 8;

    function automatic bit cf_is_part_start(input int idx, input int part);
        return (idx % part) == 0;
    endfunction
endpackage

// File: rtl/cf_run_tracker.sv
module cf_run_tracker
    import cf_pkg::*;
#(
    parameter int N_PADS    = CF_PADS,
    parameter int PART_PADS = CF_PART,
    parameter int MAX_SIZE  = CF_RUN,
    parameter int SIZE_W    = $clog2(MAX_SIZE)
) (
    input  logic [N_PADS-1:0]        hits_i,
    output logic [N_PADS-1:0]        start_o,
    output logic [N_PADS*SIZE_W-1:0] len_o
);
    localparam logic [SIZE_W-1:0] POS_LAST = SIZE_W'(MAX_SIZE - 1);

    // Position of each pad inside its cluster (0 = cluster head).
    logic [N_PADS*SIZE_W-1:0] pos_flat;

    always_comb begin
        logic [SIZE_W-1:0] run;
        logic              prev_hit;
        run      = '0;
        prev_hit = 1'b0;
        pos_flat = '0;
        for (int i = 0; i < N_PADS; i++) begin
            if (!hits_i[i] || !prev_hit || cf_is_part_start(i, PART_PADS) || run == POS_LAST) begin
                run = '0;
            end else begin
                run = run + 1'b1;
            end
            pos_flat[i*SIZE_W +: SIZE_W] = run;
            prev_hit = hits_i[i];
        end
    end

    // A head's length is the number of following pads continuing its count.
    always_comb begin
        start_o = '0;
        len_o   = '0;
        for (int i = 0; i < N_PADS; i++) begin
            logic [SIZE_W-1:0] extra;
            extra = '0;
            if (hits_i[i] && pos_flat[i*SIZE_W +: SIZE_W] == '0) begin
                start_o[i] = 1'b1;
                for (int k = 1; k < MAX_SIZE; k++) begin
                    if (i + k < N_PADS) begin
                        if (pos_flat[(i+k)*SIZE_W +: SIZE_W] == SIZE_W'(k)) begin
                            extra = extra + 1'b1;
                        end
                    end
                end
            end
            len_o[i*SIZE_W +: SIZE_W] = extra;
        end
    end
endmodule

// File: rtl/cf_slot_picker.sv
module cf_slot_picker
    import cf_pkg::*;
#(
    parameter int N_PADS    = CF_PADS,
    parameter int MAX_CLUST = CF_SLOTS,
    parameter int ADDR_W    = $clog2(N_PADS),
    parameter int SIZE_W    = 3
) (
    input  logic [N_PADS-1:0]           start_i,
    input  logic [N_PADS*SIZE_W-1:0]    len_i,
    output logic [MAX_CLUST-1:0]        valid_o,
    output logic [MAX_CLUST*ADDR_W-1:0] addr_o,
    output logic [MAX_CLUST*SIZE_W-1:0] size_o
);
    always_comb begin
        int taken;
        taken   = 0;
        valid_o = '0;
        addr_o  = '0;
        size_o  = '0;
        for (int i = 0; i < N_PADS; i++) begin
            if (start_i[i] && taken < MAX_CLUST) begin
                valid_o[taken]                    = 1'b1;
                addr_o[taken*ADDR_W +: ADDR_W]    = ADDR_W'(i);
                size_o[taken*SIZE_W +: SIZE_W]    = len_i[i*SIZE_W +: SIZE_W];
                taken = taken + 1;
            end
        end
    end
endmodule

// File: rtl/trig_cluster_finder.sv
module trig_cluster_finder
    import cf_pkg::*;
#(
    parameter int N_PADS    = CF_PADS,
    parameter int PART_PADS = CF_PART,
    parameter int MAX_CLUST = CF_SLOTS,
    parameter int MAX_SIZE  = CF_RUN,
    parameter int ADDR_W    = $clog2(N_PADS),
    parameter int SIZE_W    = $clog2(MAX_SIZE)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PADS-1:0]           pad_hits,
    output logic [MAX_CLUST-1:0]        clu_valid,
    output logic [MAX_CLUST*ADDR_W-1:0] clu_addr,
    output logic [MAX_CLUST*SIZE_W-1:0] clu_size
);
    // Stage 1: capture the pad vector.
    logic [N_PADS-1:0] hits_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hits_q <= '0;
        else        hits_q <= pad_hits;
    end

    // Stage 2: cluster heads and lengths.
    logic [N_PADS-1:0]        start_d, start_q;
    logic [N_PADS*SIZE_W-1:0] len_d, len_q;

    cf_run_tracker #(
        .N_PADS   (N_PADS),
        .PART_PADS(PART_PADS),
        .MAX_SIZE (MAX_SIZE),
        .SIZE_W   (SIZE_W)
    ) u_tracker (
        .hits_i (hits_q),
        .start_o(start_d),
        .len_o  (len_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            len_q   <= '0;
        end else begin
            start_q <= start_d;
            len_q   <= len_d;
        end
    end

    // Stage 3: ordered slot selection into the output register.
    logic [MAX_CLUST-1:0]        valid_d;
    logic [MAX_CLUST*ADDR_W-1:0] addr_d;
    logic [MAX_CLUST*SIZE_W-1:0] size_d;

    cf_slot_picker #(
        .N_PADS   (N_PADS),
        .MAX_CLUST(MAX_CLUST),
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W)
    ) u_picker (
        .start_i(start_q),
        .len_i  (len_q),
        .valid_o(valid_d),
        .addr_o (addr_d),
        .size_o (size_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clu_valid <= '0;
            clu_addr  <= '0;
            clu_size  <= '0;
        end else begin
            clu_valid <= valid_d;
            clu_addr  <= addr_d;
            clu_size  <= size_d;
        end
    end
endmodule

// File: rtl/cf_checker.sv
module cf_checker #(
    parameter int N_PADS    = 1536,
    parameter int PART_PADS = 192,
    parameter int MAX_CLUST = 8,
    parameter int ADDR_W    = 11,
    parameter int SIZE_W    = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_PADS-1:0]           pad_hits,
    input logic [MAX_CLUST-1:0]        clu_valid,
    input logic [MAX_CLUST*ADDR_W-1:0] clu_addr,
    input logic [MAX_CLUST*SIZE_W-1:0] clu_size
);
    logic [N_PADS-1:0] h1, h2, h3;
    logic [1:0]        warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0;
            warm <= '0;
        end else begin
            h1 <= pad_hits; h2 <= h1; h3 <= h2;
            if (warm != 2'd3) warm <= warm + 2'd1;
        end
    end

    wire ready = (warm == 2'd3);

    assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> clu_valid == '0);

    assert_empty_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && h3 == '0) |-> clu_valid == '0);

    assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && h3 != '0) |-> clu_valid[0]);

    for (genvar k = 0; k < MAX_CLUST; k++) begin : g_slot
        wire [ADDR_W-1:0] a = clu_addr[k*ADDR_W +: ADDR_W];
        wire [SIZE_W-1:0] s = clu_size[k*SIZE_W +: SIZE_W];

        assert_head_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && clu_valid[k]) |->
                (int'(a) + int'(s) < N_PADS) && h3[int'(a)] && h3[int'(a) + int'(s)]);

        assert_in_partition_R4: assert property (@(posedge clk) disable iff (!rst_n)
            clu_valid[k] |-> (int'(a) % PART_PADS) + int'(s) < PART_PADS);

        assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !clu_valid[k] |-> (a == '0 && s == '0));

        if (k > 0) begin : g_ord
            wire [ADDR_W-1:0] ap = clu_addr[(k-1)*ADDR_W +: ADDR_W];
            assert_rising_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
                clu_valid[k] |-> (clu_valid[k-1] && a > ap));
        end
    end
endmodule

bind trig_cluster_finder cf_checker #(
    .N_PADS   (N_PADS),
    .PART_PADS(PART_PADS),
    .MAX_CLUST(MAX_CLUST),
    .ADDR_W   (ADDR_W),
    .SIZE_W   (SIZE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_hits (pad_hits),
    .clu_valid(clu_valid),
    .clu_addr (clu_addr),
    .clu_size (clu_size)
);

// File: tb/trig_cluster_finder_tb.sv
module trig_cluster_finder_tb;
    localparam int N  = 48;
    localparam int PP = 12;
    localparam int MC = 4;
    localparam int MS = 4;
    localparam int AW = $clog2(N);
    localparam int SW = $clog2(MS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      pad_hits = '0;
    logic [MC-1:0]     clu_valid;
    logic [MC*AW-1:0]  clu_addr;
    logic [MC*SW-1:0]  clu_size;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    trig_cluster_finder #(
        .N_PADS(N), .PART_PADS(PP), .MAX_CLUST(MC), .MAX_SIZE(MS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pad_hits(pad_hits),
        .clu_valid(clu_valid), .clu_addr(clu_addr), .clu_size(clu_size)
    );

    // Reference list built by walking pads and measuring each run.
    task automatic model(input logic [N-1:0] v, output logic [MC-1:0] ev,
                         output logic [MC*AW-1:0] ea, output logic [MC*SW-1:0] es);
        int p, len, n;
        ev = '0; ea = '0; es = '0;
        p = 0; n = 0;
        while (p < N) begin
            if (v[p]) begin
                len = 1;
                while (p + len < N && v[p+len] && len < MS && ((p + len) % PP) != 0)
                    len++;
                if (n < MC) begin
                    ev[n] = 1'b1;
                    ea[n*AW +: AW] = AW'(p);
                    es[n*SW +: SW] = SW'(len - 1);
                end
                n++;
                p += len;
            end else begin
                p++;
            end
        end
    endtask

    task automatic compare(input logic [N-1:0] v, input string tag);
        logic [MC-1:0] ev; logic [MC*AW-1:0] ea; logic [MC*SW-1:0] es;
        model(v, ev, ea, es);
        checks++;
        if (clu_valid !== ev || clu_addr !== ea || clu_size !== es) begin
            fails++;
            $display("FAIL %s vec=%h: valid=%b addr=%h size=%h expected valid=%b addr=%h size=%h",
                     tag, v, clu_valid, clu_addr, clu_size, ev, ea, es);
        end
    endtask

    task automatic check_slot(input int k, input bit v, input int a, input int s, input string tag);
        checks++;
        if (clu_valid[k] !== v || clu_addr[k*AW +: AW] !== AW'(a) || clu_size[k*SW +: SW] !== SW'(s)) begin
            fails++;
            $display("FAIL %s slot %0d: v=%b a=%0d s=%0d expected v=%b a=%0d s=%0d", tag, k,
                     clu_valid[k], clu_addr[k*AW +: AW], clu_size[k*SW +: SW], v, a, s);
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (clu_valid !== '0) begin
            fails++;
            $display("FAIL %s: valid=%b expected valid=0", tag, clu_valid);
        end
    endtask

    // Drive one vector, zeros afterwards; return at the sampling point of its result.
    task automatic fire(input logic [N-1:0] v);
        @(negedge clk) pad_hits = v;
        @(negedge clk) pad_hits = '0;
        @(negedge clk) check_idle("R2 early");
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] mkvec(input int t);
        logic [11:0] p;
        p = 12'(t);
        return {p, ~p, p ^ 12'hA5C, {p[5:0], p[11:6]}};
    endfunction

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] vh [4];

        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        pad_hits = '1;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) check_idle("R1 after release");
        pad_hits = '0;
        repeat (3) @(negedge clk);

        // R3: one isolated run of three pads
        v = '0; v[7:5] = 3'b111;
        fire(v);
        check_slot(0, 1, 5, 2, "R3");
        check_slot(1, 0, 0, 0, "R3");
        compare(v, "R3");
        @(negedge clk) check_idle("R2 single crossing");

        // R4: run 10..13 crosses partition edge at 12
        v = '0; v[13:10] = 4'hF;
        fire(v);
        check_slot(0, 1, 10, 1, "R4");
        check_slot(1, 1, 12, 1, "R4");

        // R5: nine-pad run 1..9 with cap 4
        v = '0; v[9:1] = '1;
        fire(v);
        check_slot(0, 1, 1, 3, "R5");
        check_slot(1, 1, 5, 3, "R5");
        check_slot(2, 1, 9, 0, "R5");
        check_slot(3, 0, 0, 0, "R5");

        // R6: clusters at 40, 20, 3 come out in rising order
        v = '0; v[40] = 1'b1; v[20] = 1'b1; v[3] = 1'b1;
        fire(v);
        check_slot(0, 1, 3, 0, "R6");
        check_slot(1, 1, 20, 0, "R6");
        check_slot(2, 1, 40, 0, "R6");
        check_slot(3, 0, 0, 0, "R6");

        // R7: eight single pads, only the lowest four survive
        v = '0;
        for (int i = 0; i < 16; i += 2) v[i] = 1'b1;
        fire(v);
        check_slot(0, 1, 0, 0, "R7");
        check_slot(3, 1, 6, 0, "R7");
        compare(v, "R7");

        // R8: four sizes in four slots, field positions
        v = '0; v[0] = 1'b1; v[3:2] = 2'b11; v[7:5] = 3'b111; v[16:13] = 4'hF;
        fire(v);
        check_slot(0, 1, 0, 0, "R8");
        check_slot(1, 1, 2, 1, "R8");
        check_slot(2, 1, 5, 2, "R8");
        check_slot(3, 1, 13, 3, "R8");

        // Back-to-back sweep: a new vector every clock
        for (int t = 0; t < 4096 + 3; t++) begin
            @(negedge clk);
            if (t >= 3) compare(vh[(t - 3) % 4], "R2 R3 R4 R5 R6 R7 sweep");
            pad_hits = (t < 4096) ? mkvec(t) : '0;
            vh[t % 4] = pad_hits;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule